// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block sits beside a USB host controller's schedule walker. For each transfer descriptor the walker has executed, it takes the descriptor's 32-bit control word, its 32-bit token word, the outcome of the bus transaction and the number of bytes moved. From these it works out the new control word to write back and a verdict for the walker: advance to the next descriptor, keep the current one, or abandon the rest of the frame. It also raises per-descriptor interrupt causes and error flags for the register core. As a side product it unpacks the token into packet ID, device address, endpoint and maximum length, which a packet engine can use.

The unit handles one descriptor per request through a ready/valid pair on each side. It is driven by a three-state machine. In `S_IDLE` it holds `req_ready` high and captures a request on `req_valid` (transition IDLE→EVAL). In `S_EVAL` it registers the evaluated results (transition EVAL→DONE, always taken). In `S_DONE` it holds `rsp_valid` high with stable results until `rsp_ready`, and then returns to idle (transition DONE→IDLE).

Result code encoding on `xact_code`: 0 = completed, 1 = NAK, 2 = STALL, 3 = timeout, 4 = babble. Any other code leaves the word unchanged with verdict keep. Verdict encoding on `verdict`: 0 = advance, 1 = keep, 2 = stop frame. Recognised packet IDs are SETUP 0x2D, IN 0x69 and OUT 0xE1.

Top module: `td_status_updater`

## Requirements
- R1: `pid_o` is token bits 7:0, `dev_addr_o` is token bits 14:8 and `endp_o` is token bits 18:15 of the captured request, valid while `rsp_valid` is high.
- R2: `max_len_o` is (token bits 31:21 + 1) modulo 2048, so a field of 0x7FF gives zero bytes and 0x007 gives eight.
- R3: If control bit 23 (active) is clear, the control word is returned unchanged with verdict keep and no error flag set. This holds even when the packet ID is invalid.
- R4: Control bit 24 set raises `int_cause[0]`, whether or not the descriptor is active.
- R5: A completed transaction with a byte count no larger than the maximum writes (count − 1) mod 2048 into control bits 10:0, clears bit 23 and gives verdict advance.
- R6: An IN descriptor with control bit 29 set that completes with fewer bytes than the maximum raises `int_cause[1]` and gives verdict keep. Its length field is still updated and bit 23 is still cleared.
- R7: A completed transaction whose byte count exceeds the maximum is handled exactly as babble.
- R8: Babble sets control bits 20 and 22, clears bit 23 and gives verdict stop.
- R9: A timeout sets control bit 18 and decrements the count in bits 28:27. When the count reaches zero, bit 23 is cleared and `usb_err` is raised. The verdict is keep.
- R10: A timeout with a count already at zero leaves the count at zero and bit 23 set, and does not raise `usb_err`.
- R11: NAK sets bit 19 and leaves bit 23 set. STALL sets bit 22 and clears bit 23. Both give verdict keep.
- R12: An active descriptor with a packet ID other than SETUP, IN or OUT raises `proc_err`, gives verdict stop and returns the control word unchanged.
- R13: `req_ready` is high only while idle. Results appear two clock edges after the request edge and are held unchanged while `rsp_valid` is high and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| ctrl_in | input | 32 | Descriptor control word |
| token_in | input | 32 | Descriptor token word |
| xact_code | input | 3 | Transaction outcome code |
| xfer_len | input | 12 | Bytes moved in the transaction |
| rsp_valid | output | 1 | Results present |
| rsp_ready | input | 1 | Consumer takes results |
| ctrl_out | output | 32 | Updated control word |
| verdict | output | 2 | 0 advance, 1 keep, 2 stop |
| int_cause | output | 2 | Bit 0 completion interrupt, bit 1 short packet |
| usb_err | output | 1 | Error count expired |
| proc_err | output | 1 | Invalid packet ID |
| pid_o | output | 8 | Decoded packet ID |
| dev_addr_o | output | 7 | Decoded device address |
| endp_o | output | 4 | Decoded endpoint |
| max_len_o | output | 11 | Decoded maximum length in bytes |

## Verification
The bench applies each outcome code to an active descriptor. It compares OUT, IN and SETUP packets so that the short-packet path fires only for IN descriptors with short detection enabled and a short count. Byte counts equal to, below and one above the maximum separate normal completion from the short-packet path and from the length overrun that is treated as babble. The zero-byte length code is included as well. Timeouts start from counts of three, one and zero, which tells plain decrement apart from expiry and from the case where the count is already exhausted. Inactive descriptors and invalid packet IDs show which of the two checks takes precedence, and a held response shows that the results stay stable under backpressure.

// File: rtl/td_pkg.sv
package td_pkg;
    localparam int CW       = 32;
    localparam int LEN_W    = 11;
    localparam int CNT_W    = LEN_W + 1;

    localparam logic [7:0] PID_SETUP = 8'h2D;
    localparam logic [7:0] PID_IN    = 8'h69;
    localparam logic [7:0] PID_OUT   = 8'hE1;

    localparam int B_ACTIVE = 23;
    localparam int B_IOC    = 24;
    localparam int B_SPD    = 29;
    localparam int B_TMO    = 18;
    localparam int B_NAK    = 19;
    localparam int B_BABL   = 20;
    localparam int B_STALL  = 22;
    localparam int B_ERRLO  = 27;

    typedef enum logic [2:0] {
        XACT_DONE    = 3'd0,
        XACT_NAK     = 3'd1,
        XACT_STALL   = 3'd2,
        XACT_TIMEOUT = 3'd3,
        XACT_BABBLE  = 3'd4
    } xact_e;

    typedef enum logic [1:0] {
        VERD_ADVANCE = 2'd0,
        VERD_KEEP    = 2'd1,
        VERD_STOP    = 2'd2
    } verdict_e;
endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
    import td_pkg::*;
(
    input  logic [CW-1:0]    token,
    output logic [7:0]       pid,
    output logic [6:0]       dev_addr,
    output logic [3:0]       endp,
    output logic [LEN_W-1:0] max_len
);
    logic [1:0] tok_unused;

    assign pid        = token[7:0];
    assign dev_addr   = token[14:8];
    assign endp       = token[18:15];
    assign tok_unused = token[20:19];
    // field holds length minus one; the add wraps at the field width
    assign max_len    = token[CW-1:CW-LEN_W] + LEN_W'(1);
endmodule

// File: rtl/td_status_eval.sv
module td_status_eval
    import td_pkg::*;
(
    input  logic [CW-1:0]    ctrl,
    input  logic [7:0]       pid,
    input  logic [LEN_W-1:0] max_len,
    input  logic [2:0]       code,
    input  logic [CNT_W-1:0] nbytes,
    output logic [CW-1:0]    ctrl_new,
    output logic [1:0]       verd,
    output logic [1:0]       cause,
    output logic             uerr,
    output logic             perr
);
    logic             pid_ok;
    logic             overrun;
    logic             short_pkt;
    logic             babble;
    logic [1:0]       cnt;

    assign pid_ok    = (pid == PID_SETUP) || (pid == PID_IN) || (pid == PID_OUT);
    assign overrun   = nbytes > {1'b0, max_len};
    assign short_pkt = nbytes < {1'b0, max_len};
    assign cnt       = ctrl[B_ERRLO+1:B_ERRLO];

    always_comb begin
        ctrl_new = ctrl;
        verd     = VERD_KEEP;
        cause    = {1'b0, ctrl[B_IOC]};
        uerr     = 1'b0;
        perr     = 1'b0;
        babble   = 1'b0;
        if (!ctrl[B_ACTIVE]) begin
            verd = VERD_KEEP;
        end else if (!pid_ok) begin
            perr = 1'b1;
            verd = VERD_STOP;
        end else begin
            case (code)
                XACT_DONE: begin
                    if (overrun) begin
                        babble = 1'b1;
                    end else begin
                        ctrl_new[LEN_W-1:0] = nbytes[LEN_W-1:0] - LEN_W'(1);
                        ctrl_new[B_ACTIVE]  = 1'b0;
                        if (pid == PID_IN && ctrl[B_SPD] && short_pkt) begin
                            cause[1] = 1'b1;
                            verd     = VERD_KEEP;
                        end else begin
                            verd = VERD_ADVANCE;
                        end
                    end
                end
                XACT_BABBLE: babble = 1'b1;
                XACT_NAK:    ctrl_new[B_NAK] = 1'b1;
                XACT_STALL: begin
                    ctrl_new[B_STALL]  = 1'b1;
                    ctrl_new[B_ACTIVE] = 1'b0;
                end
                XACT_TIMEOUT: begin
                    ctrl_new[B_TMO] = 1'b1;
                    if (cnt != 2'd0) begin
                        ctrl_new[B_ERRLO+1:B_ERRLO] = cnt - 2'd1;
                        if (cnt == 2'd1) begin
                            ctrl_new[B_ACTIVE] = 1'b0;
                            uerr               = 1'b1;
                        end
                    end
                end
                default: verd = VERD_KEEP;
            endcase
            if (babble) begin
                ctrl_new[B_BABL]   = 1'b1;
                ctrl_new[B_STALL]  = 1'b1;
                ctrl_new[B_ACTIVE] = 1'b0;
                verd               = VERD_STOP;
            end
        end
    end
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
    import td_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] ctrl_in,
    input  logic [31:0] token_in,
    input  logic [2:0]  xact_code,
    input  logic [11:0] xfer_len,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] ctrl_out,
    output logic [1:0]  verdict,
    output logic [1:0]  int_cause,
    output logic        usb_err,
    output logic        proc_err,
    output logic [7:0]  pid_o,
    output logic [6:0]  dev_addr_o,
    output logic [3:0]  endp_o,
    output logic [10:0] max_len_o
);
    typedef enum logic [1:0] {S_IDLE, S_EVAL, S_DONE} state_e;

    state_e state, state_nx;

    logic [CW-1:0]    ctrl_q, token_q;
    logic [2:0]       code_q;
    logic [CNT_W-1:0] len_q;

    logic [CW-1:0]    ev_ctrl;
    logic [1:0]       ev_verd, ev_cause;
    logic             ev_uerr, ev_perr;

    td_token_decode u_dec (
        .token    (token_q),
        .pid      (pid_o),
        .dev_addr (dev_addr_o),
        .endp     (endp_o),
        .max_len  (max_len_o)
    );

    td_status_eval u_eval (
        .ctrl     (ctrl_q),
        .pid      (pid_o),
        .max_len  (max_len_o),
        .code     (code_q),
        .nbytes   (len_q),
        .ctrl_new (ev_ctrl),
        .verd     (ev_verd),
        .cause    (ev_cause),
        .uerr     (ev_uerr),
        .perr     (ev_perr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (req_valid) state_nx = S_EVAL;
            S_EVAL: state_nx = S_DONE;
            S_DONE: if (rsp_ready) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // handshake outputs
    always_comb begin
        req_ready = (state == S_IDLE);
        rsp_valid = (state == S_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            token_q   <= '0;
            code_q    <= '0;
            len_q     <= '0;
            ctrl_out  <= '0;
            verdict   <= VERD_KEEP;
            int_cause <= '0;
            usb_err   <= 1'b0;
            proc_err  <= 1'b0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                ctrl_q  <= ctrl_in;
                token_q <= token_in;
                code_q  <= xact_code;
                len_q   <= xfer_len;
            end
            if (state == S_EVAL) begin
                ctrl_out  <= ev_ctrl;
                verdict   <= ev_verd;
                int_cause <= ev_cause;
                usb_err   <= ev_uerr;
                proc_err  <= ev_perr;
            end
        end
    end
endmodule

// File: rtl/td_status_chk.sv
module td_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] ctrl_out,
    input logic [1:0]  verdict,
    input logic        usb_err,
    input logic        proc_err
);
    // R13
    ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    // R13
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !rsp_valid ##1 rsp_valid);

    // R13
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(ctrl_out) && $stable(verdict)));

    // R12
    perr_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && proc_err) |-> (verdict == 2'd2 && !usb_err));

    // R5
    advance_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && verdict == 2'd0) |-> !ctrl_out[23]);

    // R9
    uerr_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && usb_err) |-> (!ctrl_out[23] && ctrl_out[28:27] == 2'd0 && ctrl_out[18]));

    // R8
    verdict_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> verdict != 2'd3);
endmodule

bind td_status_updater td_status_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .ctrl_out  (ctrl_out),
    .verdict   (verdict),
    .usb_err   (usb_err),
    .proc_err  (proc_err)
);

// File: tb/td_status_updater_tb_top.sv
`timescale 1ns/1ps
module td_status_updater_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] ctrl_in = '0;
    logic [31:0] token_in = '0;
    logic [2:0]  xact_code = '0;
    logic [11:0] xfer_len = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] ctrl_out;
    logic [1:0]  verdict;
    logic [1:0]  int_cause;
    logic        usb_err;
    logic        proc_err;
    logic [7:0]  pid_o;
    logic [6:0]  dev_addr_o;
    logic [3:0]  endp_o;
    logic [10:0] max_len_o;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] ctrl;
        logic [1:0]  verd;
        logic [1:0]  cause;
        logic        uerr;
        logic        perr;
        logic [7:0]  pid;
        logic [6:0]  addr;
        logic [3:0]  ep;
        logic [10:0] mlen;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    td_status_updater dut_i (.*);

    function automatic logic [31:0] mk_tok(input logic [10:0] mlm1, input logic [3:0] ep,
                                           input logic [6:0] addr, input logic [7:0] pid);
        return {mlm1, 2'b00, ep, addr, pid};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errs++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic send(input string tag, input logic [31:0] c, input logic [31:0] t,
                        input logic [2:0] code, input logic [11:0] n,
                        input logic [31:0] ec, input logic [1:0] ev, input logic [1:0] ecause,
                        input logic eu, input logic ep, input logic [10:0] emlen);
        exp_t e;
        e.ctrl = ec; e.verd = ev; e.cause = ecause; e.uerr = eu; e.perr = ep;
        e.pid = t[7:0]; e.addr = t[14:8]; e.ep = t[18:15]; e.mlen = emlen;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; ctrl_in = c; token_in = t; xact_code = code; xfer_len = n;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk("R13", "unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t  e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(tg, "ctrl_out", ctrl_out, e.ctrl);
                chk(tg, "verdict", {30'd0, verdict}, {30'd0, e.verd});
                chk(tg, "int_cause", {30'd0, int_cause}, {30'd0, e.cause});
                chk(tg, "errors", {30'd0, usb_err, proc_err}, {30'd0, e.uerr, e.perr});
                chk("R1", "decode", {13'd0, pid_o, dev_addr_o, endp_o}, {13'd0, e.pid, e.addr, e.ep});
                chk("R2", "max_len", {21'd0, max_len_o}, {21'd0, e.mlen});
            end
        end
    end

    initial begin
        int wd = 0;
        while (!finished && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!finished) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] t8o, t8i, t0s;
        t8o = mk_tok(11'd7, 4'd3, 7'h05, 8'hE1);
        t8i = mk_tok(11'd7, 4'd1, 7'h12, 8'h69);
        t0s = mk_tok(11'h7FF, 4'd0, 7'h00, 8'h2D);
        repeat (3) @(negedge clk);
        chk("R13", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "idle req_ready", {31'd0, req_ready}, 32'd1);

        // R5 OUT completes at full length
        send("R5", 32'h1880_0000, t8o, 3'd0, 12'd8, 32'h1800_0007, 2'd0, 2'b00, 0, 0, 11'd8);
        // R6 R4 short IN with SPD and IOC
        send("R6", 32'h2180_0000, t8i, 3'd0, 12'd3, 32'h2100_0002, 2'd1, 2'b11, 0, 0, 11'd8);
        // R6 IN with SPD at full length advances
        send("R6", 32'h2080_0000, t8i, 3'd0, 12'd8, 32'h2000_0007, 2'd0, 2'b00, 0, 0, 11'd8);
        // R7 overrun by one byte
        send("R7", 32'h0080_0000, t8i, 3'd0, 12'd9, 32'h0050_0000, 2'd2, 2'b00, 0, 0, 11'd8);
        // R8 babble outcome
        send("R8", 32'h1880_0000, t8o, 3'd4, 12'd0, 32'h1850_0000, 2'd2, 2'b00, 0, 0, 11'd8);
        // R11 NAK
        send("R11", 32'h1880_0000, t8o, 3'd1, 12'd0, 32'h1888_0000, 2'd1, 2'b00, 0, 0, 11'd8);
        // R11 STALL
        send("R11", 32'h1880_0000, t8o, 3'd2, 12'd0, 32'h1840_0000, 2'd1, 2'b00, 0, 0, 11'd8);
        // R9 timeout from count 3
        send("R9", 32'h1880_0000, t8o, 3'd3, 12'd0, 32'h1084_0000, 2'd1, 2'b00, 0, 0, 11'd8);
        // R9 timeout from count 1 expires
        send("R9", 32'h0880_0000, t8o, 3'd3, 12'd0, 32'h0004_0000, 2'd1, 2'b00, 1, 0, 11'd8);
        // R10 timeout at count 0
        send("R10", 32'h0080_0000, t8o, 3'd3, 12'd0, 32'h0084_0000, 2'd1, 2'b00, 0, 0, 11'd8);
        // R3 R4 inactive with IOC and bad pid
        send("R3", 32'h0100_0000, mk_tok(11'd7, 4'd2, 7'h01, 8'h55), 3'd0, 12'd4,
             32'h0100_0000, 2'd1, 2'b01, 0, 0, 11'd8);
        // R12 active with bad pid
        send("R12", 32'h0080_0000, mk_tok(11'd7, 4'd2, 7'h01, 8'h55), 3'd0, 12'd4,
             32'h0080_0000, 2'd2, 2'b00, 0, 1, 11'd8);
        // R2 R5 zero-length code, SETUP, zero bytes
        send("R2", 32'h0080_0000, t0s, 3'd0, 12'd0, 32'h0000_07FF, 2'd0, 2'b00, 0, 0, 11'd0);
        // R7 zero-length code, one byte overruns
        send("R7", 32'h0080_0000, t0s, 3'd0, 12'd1, 32'h0050_0000, 2'd2, 2'b00, 0, 0, 11'd0);

        // R13 backpressure and latency
        while (exp_q.size() != 0) @(negedge clk);
        rsp_ready = 1'b0;
        send("R13", 32'h1880_0000, t8o, 3'd0, 12'd8, 32'h1800_0007, 2'd0, 2'b00, 0, 0, 11'd8);
        chk("R13", "no result one edge after accept", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R13", "result two edges after accept", {31'd0, rsp_valid}, 32'd1);
        repeat (4) @(negedge clk);
        chk("R13", "held while stalled", {31'd0, rsp_valid}, 32'd1);
        chk("R13", "not ready while holding", {31'd0, req_ready}, 32'd0);
        chk("R13", "ctrl stable while stalled", ctrl_out, 32'h1800_0007);
        rsp_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R13", "queue drained", exp_q.size(), 32'd0);
        chk("R13", "back to idle", {31'd0, req_ready}, 32'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule